// File: doc/BRIEF.md
# Byte-Lane SRAM Array Emulator

This block gives a clocked, synthesizable stand-in for a 16-bit static memory whose control pins follow an asynchronous SRAM truth table. It decodes a pair of chip selects of opposite polarity, an active-low write strobe, an active-low output enable and two active-low byte enables. From these it performs byte-lane reads or writes on an array whose depth is set by a parameter. It replaces a board-level SRAM inside a larger design, so logic built for that pin protocol can run against on-chip storage.

The bidirectional data bus is split into a write-data input, a read-data output and one drive flag per byte lane, so the block has no tri-state logic. A lane whose flag is low is treated as high impedance and reads as zero. Writes commit on the rising clock edge. Read data and drive flags are registered together and appear one cycle after the read condition. A status output gives the currently decoded mode, and a separate flag marks standby.

Top module: `byte_lane_sram_emu`

## Requirements
- R1: When the active-low select is high or the active-high select is low, the block is in standby. The mode code is 0 and the standby flag is 1. No lane is written, and both drive flags are 0 on the following cycle, whatever the other controls are.
- R2: When the block is selected but both byte enables are high, it is also in standby. The mode code is 0 and the standby flag is 1. Nothing is written, and both drive flags are 0 on the next cycle.
- R3: When the block is selected, write enable is low and at least one byte enable is low, the cycle is a write (mode code 3), whatever the output enable level. The data is stored at the clock edge.
- R4: During a write, only lanes whose byte enable is low are updated. Byte enable bit 0 guards data bits 7..0 and bit 1 guards bits 15..8. A disabled lane keeps its old contents.
- R5: When the block is selected, write enable is high, output enable is low and at least one byte enable is low, the cycle is a read (mode code 2). The stored word appears on the read-data output one cycle later.
- R6: When the block is selected with write enable high and output enable high, the outputs are disabled (mode code 1). Both drive flags are 0 on the next cycle and nothing is written.
- R7: On a read, drive flag bit k is 1 on the next cycle exactly when byte enable bit k was low. A lane whose drive flag is 0 presents zero on its read-data bits.
- R8: A write never drives the bus. Both drive flags are 0 on the cycle after a write, even when output enable is low.
- R9: While reset is asserted, both drive flags are 0 and the read-data output is zero. This also holds when reset arrives during a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| sel_n_i | input | 1 | Active-low chip select |
| sel_i | input | 1 | Active-high chip select |
| wr_n_i | input | 1 | Active-low write enable |
| oe_n_i | input | 1 | Active-low output enable |
| lane_en_n_i | input | 2 | Active-low byte enables; bit 0 lower byte, bit 1 upper byte |
| addr_i | input | ADDR_W (10) | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data, zero on lanes not driven |
| lane_drive_o | output | 2 | Registered per-lane drive flags |
| mode_o | output | 2 | Decoded mode: 0 standby, 1 output off, 2 read, 3 write |
| standby_o | output | 1 | High while the decoded mode is standby |

## Verification
The bench writes one lane at a time and reads both lanes back. A design that ignored a byte enable would overwrite the neighbouring byte, and one that swapped the lanes would return bytes in the wrong halves. It attempts writes with each chip select inactive, and with both byte enables high, and then reads the word back intact. A decoder that missed either select polarity or the no-lane case would corrupt that word. It also issues a write with output enable low and single-lane reads. A design that let output enable win over a write would raise the drive flags, and one that left an idle lane's data visible would show stale bytes. Reset is applied during a read to catch drive flags that are not cleared.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

   typedef enum logic [1:0] {
      MODE_STANDBY = 2'd0,
      MODE_OFF     = 2'd1,
      MODE_READ    = 2'd2,
      MODE_WRITE   = 2'd3
   } sram_mode_e;

   localparam int unsigned FULL_ADDR_W = 19;

endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
   import sram_emu_pkg::*;
#(
   parameter int unsigned NUM_LANES = 2
) (
   input  logic                 sel_n_i,
   input  logic                 sel_i,
   input  logic                 wr_n_i,
   input  logic                 oe_n_i,
   input  logic [NUM_LANES-1:0] lane_en_n_i,
   output sram_mode_e           mode_o,
   output logic [NUM_LANES-1:0] wr_lane_o,
   output logic [NUM_LANES-1:0] rd_lane_o
);

   logic chip_on;
   logic any_lane;

   assign chip_on  = !sel_n_i && sel_i;
   assign any_lane = !(&lane_en_n_i);

   always_comb begin
      if (!chip_on || !any_lane) begin
         mode_o = MODE_STANDBY;
      end else if (!wr_n_i) begin
         mode_o = MODE_WRITE;
      end else if (!oe_n_i) begin
         mode_o = MODE_READ;
      end else begin
         mode_o = MODE_OFF;
      end
   end

   always_comb begin
      wr_lane_o = '0;
      rd_lane_o = '0;
      if (mode_o == MODE_WRITE) wr_lane_o = ~lane_en_n_i;
      if (mode_o == MODE_READ)  rd_lane_o = ~lane_en_n_i;
   end

endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
   parameter int unsigned LANE_W = 8,
   parameter int unsigned ADDR_W = 10
) (
   input  logic              clk,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [LANE_W-1:0] wdata_i,
   output logic [LANE_W-1:0] rdata_o
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en_i) begin
         store[addr_i] <= wdata_i;
      end
      if (rd_en_i) begin
         rdata_o <= store[addr_i];
      end
   end

endmodule

// File: rtl/sram_read_stage.sv
module sram_read_stage #(
   parameter int unsigned NUM_LANES = 2,
   parameter int unsigned LANE_W    = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_LANES-1:0]        rd_lane_i,
   input  logic [NUM_LANES*LANE_W-1:0] lane_q_i,
   output logic [NUM_LANES*LANE_W-1:0] rdata_o,
   output logic [NUM_LANES-1:0]        drive_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive_o <= '0;
      end else begin
         drive_o <= rd_lane_i;
      end
   end

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_mask
      assign rdata_o[g*LANE_W +: LANE_W] =
         drive_o[g] ? lane_q_i[g*LANE_W +: LANE_W] : '0;
   end

endmodule

// File: rtl/byte_lane_sram_emu.sv
module byte_lane_sram_emu
   import sram_emu_pkg::*;
#(
   parameter int unsigned NUM_LANES = 2,
   parameter int unsigned LANE_W    = 8,
   parameter int unsigned ADDR_W    = 10
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        sel_n_i,
   input  logic                        sel_i,
   input  logic                        wr_n_i,
   input  logic                        oe_n_i,
   input  logic [NUM_LANES-1:0]        lane_en_n_i,
   input  logic [ADDR_W-1:0]           addr_i,
   input  logic [NUM_LANES*LANE_W-1:0] wdata_i,
   output logic [NUM_LANES*LANE_W-1:0] rdata_o,
   output logic [NUM_LANES-1:0]        lane_drive_o,
   output logic [1:0]                  mode_o,
   output logic                        standby_o
);

   localparam int unsigned DATA_W = NUM_LANES * LANE_W;

   if (ADDR_W < 1 || ADDR_W > FULL_ADDR_W) begin : g_bad_addr
      $error("ADDR_W must lie between 1 and the full-size address width");
   end
   if (NUM_LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("NUM_LANES and LANE_W must be at least 1");
   end

   sram_mode_e           mode;
   logic [NUM_LANES-1:0] wr_lane;
   logic [NUM_LANES-1:0] rd_lane;
   logic [DATA_W-1:0]    lane_q;

   sram_mode_decode #(
      .NUM_LANES (NUM_LANES)
   ) u_dec (
      .sel_n_i     (sel_n_i),
      .sel_i       (sel_i),
      .wr_n_i      (wr_n_i),
      .oe_n_i      (oe_n_i),
      .lane_en_n_i (lane_en_n_i),
      .mode_o      (mode),
      .wr_lane_o   (wr_lane),
      .rd_lane_o   (rd_lane)
   );

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      sram_lane_bank #(
         .LANE_W (LANE_W),
         .ADDR_W (ADDR_W)
      ) u_bank (
         .clk     (clk),
         .wr_en_i (wr_lane[g]),
         .rd_en_i (rd_lane[g]),
         .addr_i  (addr_i),
         .wdata_i (wdata_i[g*LANE_W +: LANE_W]),
         .rdata_o (lane_q[g*LANE_W +: LANE_W])
      );
   end

   sram_read_stage #(
      .NUM_LANES (NUM_LANES),
      .LANE_W    (LANE_W)
   ) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_lane_i (rd_lane),
      .lane_q_i  (lane_q),
      .rdata_o   (rdata_o),
      .drive_o   (lane_drive_o)
   );

   assign mode_o    = mode;
   assign standby_o = (mode == MODE_STANDBY);

endmodule

// File: rtl/byte_lane_sram_emu_chk.sv
module byte_lane_sram_emu_chk #(
   parameter int unsigned NUM_LANES = 2,
   parameter int unsigned LANE_W    = 8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        sel_n_i,
   input logic                        sel_i,
   input logic                        wr_n_i,
   input logic                        oe_n_i,
   input logic [NUM_LANES-1:0]        lane_en_n_i,
   input logic [NUM_LANES*LANE_W-1:0] rdata_o,
   input logic [NUM_LANES-1:0]        lane_drive_o,
   input logic [1:0]                  mode_o,
   input logic                        standby_o
);

   logic on;
   logic some_lane;
   assign on        = !sel_n_i && sel_i;
   assign some_lane = !(&lane_en_n_i);

   assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !on |=> lane_drive_o == '0);

   assert_no_lane_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (on && !some_lane) |-> standby_o);

   assert_write_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (on && some_lane && !wr_n_i) |-> mode_o == 2'd3);

   assert_read_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (on && some_lane && wr_n_i && !oe_n_i) |-> mode_o == 2'd2);

   assert_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (on && wr_n_i && oe_n_i) |=> lane_drive_o == '0);

   assert_read_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (on && some_lane && wr_n_i && !oe_n_i) |=> lane_drive_o == ~$past(lane_en_n_i));

   assert_write_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n_i |=> lane_drive_o == '0);

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_idle
      assert_idle_lane_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !lane_drive_o[g] |-> rdata_o[g*LANE_W +: LANE_W] == '0);
   end

endmodule

bind byte_lane_sram_emu byte_lane_sram_emu_chk #(
   .NUM_LANES (NUM_LANES),
   .LANE_W    (LANE_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sel_n_i      (sel_n_i),
   .sel_i        (sel_i),
   .wr_n_i       (wr_n_i),
   .oe_n_i       (oe_n_i),
   .lane_en_n_i  (lane_en_n_i),
   .rdata_o      (rdata_o),
   .lane_drive_o (lane_drive_o),
   .mode_o       (mode_o),
   .standby_o    (standby_o)
);

// File: tb/sim_byte_lane_sram_emu.sv
`timescale 1ns/1ps
module sim_byte_lane_sram_emu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_n_i = 1'b1;
   logic        sel_i = 1'b0;
   logic        wr_n_i = 1'b1;
   logic        oe_n_i = 1'b1;
   logic [1:0]  lane_en_n_i = 2'b11;
   logic [9:0]  addr_i = '0;
   logic [15:0] wdata_i = '0;
   logic [15:0] rdata_o;
   logic [1:0]  lane_drive_o;
   logic [1:0]  mode_o;
   logic        standby_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   byte_lane_sram_emu u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .sel_n_i      (sel_n_i),
      .sel_i        (sel_i),
      .wr_n_i       (wr_n_i),
      .oe_n_i       (oe_n_i),
      .lane_en_n_i  (lane_en_n_i),
      .addr_i       (addr_i),
      .wdata_i      (wdata_i),
      .rdata_o      (rdata_o),
      .lane_drive_o (lane_drive_o),
      .mode_o       (mode_o),
      .standby_o    (standby_o)
   );

   typedef struct packed {
      logic        sn;
      logic        s;
      logic        wn;
      logic        on;
      logic [1:0]  ben;
      logic [9:0]  adr;
      logic [15:0] wd;
      logic [1:0]  md;
      logic [1:0]  drv;
      logic [15:0] rd;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t TBL [NV] = '{
      '{1'b0,1'b1,1'b0,1'b1,2'b00,10'h3FF,16'h7777,2'd3,2'b00,16'h0000,4'd3}, // R3 write top address
      '{1'b0,1'b1,1'b0,1'b1,2'b00,10'h005,16'hA55A,2'd3,2'b00,16'h0000,4'd3}, // R3
      '{1'b0,1'b1,1'b1,1'b0,2'b00,10'h005,16'h0000,2'd2,2'b11,16'hA55A,4'd5}, // R5
      '{1'b0,1'b1,1'b0,1'b1,2'b10,10'h005,16'h1234,2'd3,2'b00,16'h0000,4'd4}, // R4 lower only
      '{1'b0,1'b1,1'b1,1'b0,2'b00,10'h005,16'h0000,2'd2,2'b11,16'hA534,4'd4}, // R4
      '{1'b0,1'b1,1'b0,1'b0,2'b01,10'h005,16'hBEEF,2'd3,2'b00,16'h0000,4'd8}, // R8 write with oe low
      '{1'b0,1'b1,1'b1,1'b0,2'b00,10'h005,16'h0000,2'd2,2'b11,16'hBE34,4'd4}, // R4 upper only
      '{1'b0,1'b1,1'b1,1'b0,2'b10,10'h005,16'h0000,2'd2,2'b01,16'h0034,4'd7}, // R7
      '{1'b0,1'b1,1'b1,1'b0,2'b01,10'h005,16'h0000,2'd2,2'b10,16'hBE00,4'd7}, // R7
      '{1'b1,1'b1,1'b0,1'b1,2'b00,10'h3FF,16'hC3C3,2'd0,2'b00,16'h0000,4'd1}, // R1 low select off
      '{1'b0,1'b0,1'b0,1'b1,2'b00,10'h3FF,16'hC3C3,2'd0,2'b00,16'h0000,4'd1}, // R1 high select off
      '{1'b0,1'b1,1'b0,1'b1,2'b11,10'h3FF,16'hC3C3,2'd0,2'b00,16'h0000,4'd2}, // R2
      '{1'b0,1'b1,1'b1,1'b1,2'b00,10'h3FF,16'hC3C3,2'd1,2'b00,16'h0000,4'd6}, // R6
      '{1'b1,1'b0,1'b1,1'b0,2'b00,10'h3FF,16'h0000,2'd0,2'b00,16'h0000,4'd1}, // R1 read in standby
      '{1'b0,1'b1,1'b1,1'b0,2'b00,10'h3FF,16'h0000,2'd2,2'b11,16'h7777,4'd1}, // R1 R2 word intact
      '{1'b0,1'b1,1'b0,1'b1,2'b00,10'h000,16'h0001,2'd3,2'b00,16'h0000,4'd3}, // R3 address zero
      '{1'b0,1'b1,1'b1,1'b0,2'b00,10'h000,16'h0000,2'd2,2'b11,16'h0001,4'd5}, // R5
      '{1'b0,1'b1,1'b1,1'b0,2'b11,10'h000,16'h0000,2'd0,2'b00,16'h0000,4'd2}  // R2 read no lane
   };

   task automatic check(input bit ok, input int req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      sel_n_i     = v.sn;
      sel_i       = v.s;
      wr_n_i      = v.wn;
      oe_n_i      = v.on;
      lane_en_n_i = v.ben;
      addr_i      = v.adr;
      wdata_i     = v.wd;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired: actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R9: reset state
      repeat (3) @(posedge clk);
      #5;
      check(lane_drive_o == 2'b00, 9, "drive in reset", {14'd0, lane_drive_o}, 16'h0);
      check(rdata_o == 16'h0, 9, "rdata in reset", rdata_o, 16'h0);
      check(standby_o == 1'b1, 1, "standby idle", {15'd0, standby_o}, 16'h1);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         apply(TBL[i]);
         #1;
         check(mode_o == TBL[i].md, int'(TBL[i].req), "mode", {14'd0, mode_o}, {14'd0, TBL[i].md});
         check(standby_o == (TBL[i].md == 2'd0), int'(TBL[i].req), "standby",
               {15'd0, standby_o}, {15'd0, TBL[i].md == 2'd0});
         @(posedge clk);
         #5;
         check(lane_drive_o == TBL[i].drv, int'(TBL[i].req), "drive",
               {14'd0, lane_drive_o}, {14'd0, TBL[i].drv});
         check(rdata_o == TBL[i].rd, int'(TBL[i].req), "rdata", rdata_o, TBL[i].rd);
      end

      // R9: reset arriving during a read clears the drive flags and data
      @(negedge clk);
      apply('{1'b0,1'b1,1'b1,1'b0,2'b00,10'h005,16'h0000,2'd2,2'b11,16'hBE34,4'd9});
      @(posedge clk);
      #5;
      check(rdata_o == 16'hBE34, 9, "read before reset", rdata_o, 16'hBE34);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(lane_drive_o == 2'b00, 9, "drive under reset", {14'd0, lane_drive_o}, 16'h0);
      @(posedge clk);
      #5;
      check(rdata_o == 16'h0, 9, "rdata under reset", rdata_o, 16'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #5;
      check(rdata_o == 16'hBE34, 5, "read after reset", rdata_o, 16'hBE34);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule